// File: doc/BRIEF.md
# Register Lane Gather/Scatter Permute Unit

This block rearranges the lanes of a packed register operand. A source word and an index word are each split into `LANES` equal fields; the unit produces a destination word of the same shape. In gather mode every destination lane reads the source lane named by its own index field. In scatter mode every source lane is written into the destination lane named by its index field. Indices may repeat, so the result can contain duplicates. A scatter defines both the collision order and the value of lanes that no index names. Element values are never changed; only their lane positions move.

Operations enter through a valid/ready port and leave through a valid/ready port, with one registered stage between them. Back-pressure works as follows. The result is held in a single output register. `in_ready` is high when that register is empty, or when its content is being taken in the same cycle (`out_ready` high). The consumer may hold `out_ready` low for as long as it likes. The result then stays unchanged, and no new operation is accepted until the consumer takes it.

Top module: `permute_unit`

## Requirements
- R1: With `in_mode` = 0 (gather), destination lane i equals source lane k, where k is the value of index field i.
- R2: With `in_mode` = 1 (scatter), source lane i is written to destination lane k, where k is the value of index field i.
- R3: In gather mode a repeated index value gives the same source element in every lane that names it.
- R4: In scatter mode, when several source lanes name one destination lane, the highest-numbered of those source lanes supplies its value.
- R5: In scatter mode, a destination lane that no index field names takes the matching lane of `in_prior`.
- R6: Lane i of a data word occupies bits [i*EW +: EW], and index field i occupies bits [i*IW +: IW] with IW = $clog2(LANES). Lane 0 sits at the least significant end. `LANES` must be a power of two, so every index value names a lane.
- R7: In gather mode `in_prior` has no effect on the result.
- R8: An operation is accepted on a rising edge with `in_valid` and `in_ready` high. Its result appears with `out_valid` high right after that edge.
- R9: While `out_valid` is high and `out_ready` is low, `out_valid` stays high, `out_data` stays stable and `in_ready` is low. Each accepted operation produces exactly one output transfer, and transfers come out in acceptance order.
- R10: A synchronous active-high `rst` clears `out_valid` and `out_data` to zero, which leaves `in_ready` high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Operation can be taken this cycle |
| in_mode | input | 1 | 0 = gather, 1 = scatter |
| in_src | input | LANES*EW | Source lanes |
| in_idx | input | LANES*IW | Index fields |
| in_prior | input | LANES*EW | Fill values for unnamed scatter lanes |
| out_valid | output | 1 | Result held |
| out_ready | input | 1 | Consumer takes the result |
| out_data | output | LANES*EW | Result lanes |

## Verification
The in-line assertions check the following on every cycle: the reset state, that an accepted operation is followed by a valid result, that a stalled result stays unchanged, that gather lane 0 holds the source element its index names, and that in scatter the top source lane lands where its index points. The bench's scenarios are needed for the full lane-by-lane results. These include collisions in which a lower lane loses, the prior fill of unnamed lanes, duplicate gathers, the fact that prior is ignored in gather, and the ordering of results under long output stalls.

// File: rtl/perm_pkg.sv
package perm_pkg;
  typedef enum logic {
    MODE_GATHER  = 1'b0,
    MODE_SCATTER = 1'b1
  } perm_mode_e;
endpackage

// File: rtl/perm_gather.sv
module perm_gather #(
  parameter int EW    = 8,
  parameter int LANES = 8,
  parameter int IW    = 3
) (
  input  logic [LANES*EW-1:0] src,
  input  logic [LANES*IW-1:0] idx,
  output logic [LANES*EW-1:0] dst
);
  // each destination lane is a LANES:1 mux over the source lanes
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [IW-1:0] sel;
    assign sel = idx[g*IW +: IW];
    assign dst[g*EW +: EW] = src[sel*EW +: EW];
  end
endmodule

// File: rtl/perm_scatter.sv
module perm_scatter #(
  parameter int EW    = 8,
  parameter int LANES = 8,
  parameter int IW    = 3
) (
  input  logic [LANES*EW-1:0] src,
  input  logic [LANES*IW-1:0] idx,
  input  logic [LANES*EW-1:0] prior,
  output logic [LANES*EW-1:0] dst
);
  // each destination lane scans sources upward; a later match overrides,
  // so the highest-numbered source lane wins on collision
  for (genvar d = 0; d < LANES; d++) begin : g_dst
    logic [EW-1:0] val;
    always_comb begin
      val = prior[d*EW +: EW];
      for (int s = 0; s < LANES; s++) begin
        if (idx[s*IW +: IW] == IW'(d)) val = src[s*EW +: EW];
      end
    end
    assign dst[d*EW +: EW] = val;
  end
endmodule

// File: rtl/perm_out_stage.sv
module perm_out_stage #(
  parameter int W = 64
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_data,
  input  logic         take,
  output logic         full,
  output logic [W-1:0] data
);
  always_ff @(posedge clk) begin
    if (rst) begin
      full <= 1'b0;
      data <= '0;
    end else if (load) begin
      full <= 1'b1;
      data <= load_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end
endmodule

// File: rtl/permute_unit.sv
module permute_unit
  import perm_pkg::*;
#(
  parameter int EW    = 8,
  parameter int LANES = 8,
  localparam int IW   = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int DW   = LANES * EW
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_mode,
  input  logic [DW-1:0]      in_src,
  input  logic [LANES*IW-1:0] in_idx,
  input  logic [DW-1:0]      in_prior,
  output logic               out_valid,
  input  logic               out_ready,
  output logic [DW-1:0]      out_data
);
  localparam int TOP = LANES - 1;

  logic [DW-1:0] gath_dst, scat_dst, next_dst;
  logic          accept;
  perm_mode_e    mode;

  assign mode = perm_mode_e'(in_mode);

  perm_gather #(.EW(EW), .LANES(LANES), .IW(IW)) u_gather (
    .src(in_src), .idx(in_idx), .dst(gath_dst)
  );

  perm_scatter #(.EW(EW), .LANES(LANES), .IW(IW)) u_scatter (
    .src(in_src), .idx(in_idx), .prior(in_prior), .dst(scat_dst)
  );

  assign next_dst = (mode == MODE_SCATTER) ? scat_dst : gath_dst;

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  perm_out_stage #(.W(DW)) u_out (
    .clk(clk), .rst(rst), .load(accept), .load_data(next_dst),
    .take(out_ready), .full(out_valid), .data(out_data)
  );

  // observation wires for the checks below
  logic [IW-1:0] chk_idx0, chk_idx_top;
  logic [EW-1:0] chk_g0, chk_src_top;
  assign chk_idx0    = in_idx[0 +: IW];
  assign chk_g0      = in_src[chk_idx0*EW +: EW];
  assign chk_idx_top = in_idx[TOP*IW +: IW];
  assign chk_src_top = in_src[TOP*EW +: EW];

  assert_reset_clears_R10: assert property (@(posedge clk)
    rst |=> (!out_valid && out_data == '0));

  assert_accept_yields_R8: assert property (@(posedge clk) disable iff (rst)
    accept |=> out_valid);

  assert_stall_holds_R9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));

  assert_gather_lane0_R1: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_GATHER) |=> (out_data[0 +: EW] == $past(chk_g0)));

  assert_scatter_top_wins_R4: assert property (@(posedge clk) disable iff (rst)
    (accept && mode == MODE_SCATTER) |=>
      (out_data[$past(chk_idx_top)*EW +: EW] == $past(chk_src_top)));
endmodule

// File: tb/test_permute_unit.sv
`timescale 1ns/100ps
module test_permute_unit;
  localparam int EW = 8, LANES = 8, IW = 3, DW = EW*LANES;

  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, in_mode = 1'b0, out_ready = 1'b1;
  logic [DW-1:0] in_src = '0, in_prior = '0;
  logic [LANES*IW-1:0] in_idx = '0;
  logic in_ready, out_valid;
  logic [DW-1:0] out_data;

  permute_unit #(.EW(EW), .LANES(LANES)) i_permute_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_mode(in_mode), .in_src(in_src), .in_idx(in_idx), .in_prior(in_prior),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0, n_fail = 0;
  logic [DW-1:0] exp_q[$];
  string tag_q[$];
  bit stall_mode = 1'b0;
  int cyc = 0;
  bit done = 1'b0;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] model(input logic m, input logic [DW-1:0] s,
                                          input logic [LANES*IW-1:0] ix, input logic [DW-1:0] p);
    logic [DW-1:0] r;
    if (!m) begin
      for (int i = 0; i < LANES; i++) r[i*EW +: EW] = s[int'(ix[i*IW +: IW])*EW +: EW];
    end else begin
      r = p;
      for (int i = 0; i < LANES; i++) r[int'(ix[i*IW +: IW])*EW +: EW] = s[i*EW +: EW];
    end
    return r;
  endfunction

  function automatic logic [LANES*IW-1:0] pack_idx(input int a[LANES]);
    logic [LANES*IW-1:0] v;
    for (int i = 0; i < LANES; i++) v[i*IW +: IW] = IW'(a[i]);
    return v;
  endfunction

  // driver: offers an operation, pushes its expected result on acceptance
  task automatic drive(input logic m, input logic [DW-1:0] s, input logic [LANES*IW-1:0] ix,
                       input logic [DW-1:0] p, input string tag);
    bit taken = 1'b0;
    @(negedge clk); #1.5;
    in_valid = 1'b1; in_mode = m; in_src = s; in_idx = ix; in_prior = p;
    while (!taken) begin
      #0.2;
      if (in_ready) begin
        taken = 1'b1;
        exp_q.push_back(model(m, s, ix, p));
        tag_q.push_back(tag);
        @(negedge clk); #1.5;
        in_valid = 1'b0;
        check("R8 latency", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
      end else begin
        @(negedge clk); #1.5;
      end
    end
  endtask

  // monitor: sets out_ready, compares each transfer against the scoreboard
  logic [DW-1:0] stall_data;
  bit stalled = 1'b0;
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      #0.5;
      out_ready = !stall_mode || (cyc % 4 == 0);
      #0.5;
      if (!rst) begin
        if (stalled) begin
          check("R9 hold valid", {{(DW-1){1'b0}}, out_valid}, {{(DW-1){1'b0}}, 1'b1});
          check("R9 hold data", out_data, stall_data);
        end
        stalled = 1'b0;
        if (out_valid && out_ready) begin
          if (exp_q.size() == 0) check("R9 extra output", out_data, 'x);
          else check(tag_q.pop_front(), out_data, exp_q.pop_front());
        end else if (out_valid) begin
          check("R9 in_ready low", {{(DW-1){1'b0}}, in_ready}, '0);
          stalled = 1'b1;
          stall_data = out_data;
        end
      end
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  logic [DW-1:0] seq_src, lfsr;
  initial begin
    int rev[LANES], same[LANES], ident[LANES], half[LANES], col[LANES];
    for (int i = 0; i < LANES; i++) begin
      ident[i] = i; rev[i] = LANES-1-i; same[i] = 5;
      half[i] = (i < 4) ? 0 : i; col[i] = (i % 2 == 0) ? 2 : 6;
    end
    for (int i = 0; i < LANES; i++) seq_src[i*EW +: EW] = EW'(8'h10 + i);

    repeat (3) @(posedge clk);
    @(negedge clk); #1.0;
    check("R10 out_valid", {{(DW-1){1'b0}}, out_valid}, '0);
    check("R10 out_data", out_data, '0);
    check("R10 in_ready", {{(DW-1){1'b0}}, in_ready}, {{(DW-1){1'b0}}, 1'b1});
    rst = 1'b0;

    drive(1'b0, seq_src, pack_idx(ident), '0, "R1 gather identity");
    drive(1'b0, seq_src, pack_idx(rev), '0, "R6 gather reverse lane order");
    drive(1'b0, seq_src, pack_idx(same), '0, "R3 gather duplicates");
    drive(1'b0, seq_src, pack_idx(rev), {DW{1'b1}}, "R7 gather ignores prior");
    drive(1'b1, seq_src, pack_idx(rev), {DW{1'b1}}, "R2 scatter reverse");
    drive(1'b1, seq_src, pack_idx(same), {LANES{8'hA5}}, "R4 scatter all collide");
    drive(1'b1, seq_src, pack_idx(col), {LANES{8'h3C}}, "R4 scatter two collisions");
    drive(1'b1, seq_src, pack_idx(half), {LANES{8'hEE}}, "R5 scatter prior fill");
    // known-value check of the collision winners and fills
    begin
      logic [DW-1:0] e;
      e = {LANES{8'h3C}};
      e[2*EW +: EW] = 8'h16; e[6*EW +: EW] = 8'h17;
      check("R4 model self-check", model(1'b1, seq_src, pack_idx(col), {LANES{8'h3C}}), e);
    end

    stall_mode = 1'b1;
    lfsr = 64'h1234_5678_9ABC_DEF1;
    for (int k = 0; k < 24; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      drive(lfsr[0], lfsr, lfsr[LANES*IW+3:4], ~lfsr, lfsr[0] ? "R2 random scatter" : "R1 random gather");
    end
    stall_mode = 1'b0;
    for (int k = 0; k < 16; k++) begin
      lfsr = {lfsr[62:0], lfsr[63] ^ lfsr[62] ^ lfsr[60] ^ lfsr[59]};
      drive(lfsr[1], lfsr, lfsr[LANES*IW+9:10], {lfsr[31:0], lfsr[63:32]}, "R9 back-to-back");
    end

    while (exp_q.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule